// File: doc/BRIEF.md
# Privileged Segment Address Decoder

This block sorts each 32-bit virtual address into one of five fixed windows and decides, from the current privilege level and the error-level flag, how the address reaches memory. Two kernel windows are unmapped: their physical address is obtained by subtracting the window base, and the result is always writable. The other windows are mapped. For those, the block raises a same-cycle request to an external translation unit and forwards that unit's result code, physical address and writable flag unchanged. An access that the current privilege level may not make is refused with the bad-address code, and no translation request is raised for it.

The error-level flag changes only the low half of the address space. While the flag is set, the user window bypasses translation: the physical address equals the virtual address and the access is writable. The response is registered, so it appears one clock after the request. The translation unit is expected to answer combinationally in the cycle of its request.

Top module: `seg_addr_decoder`

## Requirements
- R1: While synchronous active-low reset is applied, and at the first edge after it, `rsp_valid`, `rsp_paddr`, `rsp_writable` and `rsp_code` are all zero.
- R2: An address with bit 31 clear and `err_level` low, in a permitted mode, raises `xl_req` in the same cycle. One cycle later the response carries `xl_code`, `xl_paddr` and `xl_writable` unchanged.
- R3: An address with bit 31 clear and `err_level` high raises no `xl_req`, in every mode. The response has `rsp_paddr` equal to the address, `rsp_writable`=1 and code match.
- R4: An address from 0x80000000 to 0x9FFFFFFF in kernel mode raises no `xl_req`. It responds with address − 0x80000000, writable, code match.
- R5: An address from 0xA0000000 to 0xBFFFFFFF in kernel mode raises no `xl_req`. It responds with address − 0xA0000000, writable, code match.
- R6: An address from 0xC0000000 to 0xDFFFFFFF is mapped (as in R2) in supervisor and kernel mode.
- R7: An address from 0xE0000000 to 0xFFFFFFFF is mapped (as in R2) in kernel mode only.
- R8: A refused access raises no `xl_req` and responds with code bad-address, `rsp_paddr`=0 and `rsp_writable`=0. Refused accesses are: any address with bit 31 set in user mode, and the two unmapped windows and the top window in supervisor mode.
- R9: Mode encoding: 2'b00 kernel, 2'b01 supervisor, 2'b10 user. The unused value 2'b11 is given user rights.
- R10: Result codes on `xl_code` and `rsp_code`: 2'b00 match, 2'b01 bad-address, 2'b10 no-match, 2'b11 invalid.
- R11: `rsp_valid` equals `req_valid` of the previous cycle. With `req_valid` low, `xl_req` stays low.
- R12: `err_level` has no effect on addresses with bit 31 set. Mapped windows still request translation, and refusals still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address presented this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_mode | input | 2 | Privilege level (R9 encoding) |
| err_level | input | 1 | Error-level flag |
| xl_req | output | 1 | Translation request for a mapped, permitted address |
| xl_code | input | 2 | Translation unit result code (R10) |
| xl_paddr | input | 32 | Translation unit physical address |
| xl_writable | input | 1 | Translation unit writable flag |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_writable | output | 1 | Writable flag |
| rsp_code | output | 2 | Result code (R10) |

## Verification
The hardest cases to reach are at the window edges, where one address bit moves an access into a window with a different rule. These pairs are 0x7FFFFFFF/0x80000000, 0x9FFFFFFF/0xA0000000, 0xBFFFFFFC/0xC0000000 and 0xDFFFFFFF/0xE0000000. A second hard case is the error-level flag combined with a high address, where the flag must be ignored. The stimulus places addresses on both sides of each edge and sweeps all four mode codes. The translation stub is loaded with distinctive non-zero values before every access, so a refused or unmapped access that wrongly forwarded the stub's values would be visible at the outputs.

// File: rtl/seg_dec_pkg.sv
// Shared types for the privileged segment address decoder.
// Assumes a 32-bit virtual address space split on its top three bits.
package seg_dec_pkg;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'b00,
        MODE_SUPER  = 2'b01,
        MODE_USER   = 2'b10,
        MODE_RSVD   = 2'b11
    } priv_mode_e;

    typedef enum logic [1:0] {
        RES_MATCH   = 2'b00,
        RES_BADADDR = 2'b01,
        RES_NOMATCH = 2'b10,
        RES_INVALID = 2'b11
    } xlat_res_e;

    // Address windows, in ascending address order.
    typedef enum logic [2:0] {
        SEG_LOW     = 3'd0,
        SEG_KDIR_C  = 3'd1,
        SEG_KDIR_U  = 3'd2,
        SEG_SUPMAP  = 3'd3,
        SEG_KMAP    = 3'd4
    } seg_e;

endpackage

// File: rtl/seg_classify.sv
// Sorts a virtual address into a window and computes the direct physical
// address for windows that bypass translation.
// Assumes ADDR_W >= 4; windows are decided by the top three address bits.
module seg_classify
    import seg_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] vaddr,
    output seg_e              seg,
    output logic [ADDR_W-1:0] direct_paddr
);
    localparam logic [ADDR_W-1:0] KDIR_C_BASE = {3'b100, {(ADDR_W-3){1'b0}}};
    localparam logic [ADDR_W-1:0] KDIR_U_BASE = {3'b101, {(ADDR_W-3){1'b0}}};

    logic [2:0] top_bits;
    assign top_bits = vaddr[ADDR_W-1 -: 3];

    // Window select from the top address bits.
    always_comb begin
        case (top_bits)
            3'b100:  seg = SEG_KDIR_C;
            3'b101:  seg = SEG_KDIR_U;
            3'b110:  seg = SEG_SUPMAP;
            3'b111:  seg = SEG_KMAP;
            default: seg = SEG_LOW;
        endcase
    end

    // Direct physical address: identity for the low window, base removed for kernel windows.
    always_comb begin
        case (seg)
            SEG_LOW:    direct_paddr = vaddr;
            SEG_KDIR_C: direct_paddr = vaddr - KDIR_C_BASE;
            SEG_KDIR_U: direct_paddr = vaddr - KDIR_U_BASE;
            default:    direct_paddr = '0;
        endcase
    end
endmodule

// File: rtl/seg_priv_check.sv
// Decides whether the current privilege level may touch a window.
// Assumes the unused mode code carries the least privilege.
module seg_priv_check
    import seg_dec_pkg::*;
(
    input  seg_e       seg,
    input  logic [1:0] mode,
    output logic       allowed
);
    priv_mode_e mode_e;
    assign mode_e = priv_mode_e'(mode);

    // Permission matrix: kernel everything, supervisor low + its own window, others low only.
    always_comb begin
        case (mode_e)
            MODE_KERNEL: allowed = 1'b1;
            MODE_SUPER:  allowed = (seg == SEG_LOW) || (seg == SEG_SUPMAP);
            default:     allowed = (seg == SEG_LOW);
        endcase
    end
endmodule

// File: rtl/seg_resp_reg.sv
// Registers the response one cycle after the request.
// Assumes synchronous active-low reset; data fields hold while idle.
module seg_resp_reg #(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_paddr,
    input  logic              in_writable,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_paddr,
    output logic              out_writable,
    output logic [CODE_W-1:0] out_code
);
    // Capture the response on a valid request; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_paddr    <= '0;
            out_writable <= 1'b0;
            out_code     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_paddr    <= in_paddr;
                out_writable <= in_writable;
                out_code     <= in_code;
            end
        end
    end
endmodule

// File: rtl/seg_addr_decoder.sv
// Top of the privileged segment address decoder. Classifies the address,
// checks privilege, raises a translation request for mapped windows and
// registers the chosen response.
// Assumes the translation unit answers combinationally in the request cycle.
module seg_addr_decoder
    import seg_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MODE_W = 2,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              err_level,
    output logic              xl_req,
    input  logic [CODE_W-1:0] xl_code,
    input  logic [ADDR_W-1:0] xl_paddr,
    input  logic              xl_writable,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_writable,
    output logic [CODE_W-1:0] rsp_code
);
    seg_e              seg;
    logic [ADDR_W-1:0] direct_paddr;
    logic              allowed;
    logic              mapped;
    logic [ADDR_W-1:0] nxt_paddr;
    logic              nxt_writable;
    logic [CODE_W-1:0] nxt_code;

    seg_classify #(.ADDR_W(ADDR_W)) u_classify (
        .vaddr        (req_vaddr),
        .seg          (seg),
        .direct_paddr (direct_paddr)
    );

    seg_priv_check u_priv (
        .seg     (seg),
        .mode    (req_mode),
        .allowed (allowed)
    );

    // Mapped windows: low window outside error level, and the two upper windows.
    always_comb begin
        case (seg)
            SEG_LOW:    mapped = !err_level;
            SEG_SUPMAP: mapped = 1'b1;
            SEG_KMAP:   mapped = 1'b1;
            default:    mapped = 1'b0;
        endcase
    end

    // Translation request only for permitted mapped accesses.
    assign xl_req = req_valid && allowed && mapped;

    // Response select: refuse, forward translation, or direct map.
    always_comb begin
        if (!allowed) begin
            nxt_paddr    = '0;
            nxt_writable = 1'b0;
            nxt_code     = CODE_W'(RES_BADADDR);
        end else if (mapped) begin
            nxt_paddr    = xl_paddr;
            nxt_writable = xl_writable;
            nxt_code     = xl_code;
        end else begin
            nxt_paddr    = direct_paddr;
            nxt_writable = 1'b1;
            nxt_code     = CODE_W'(RES_MATCH);
        end
    end

    seg_resp_reg #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (req_valid),
        .in_paddr     (nxt_paddr),
        .in_writable  (nxt_writable),
        .in_code      (nxt_code),
        .out_valid    (rsp_valid),
        .out_paddr    (rsp_paddr),
        .out_writable (rsp_writable),
        .out_code     (rsp_code)
    );

    // R8: user level never requests translation of a high address.
    p_user_no_high_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b10 && req_vaddr[ADDR_W-1]) |-> !xl_req);

    // R4/R5: kernel direct windows never request translation.
    p_kdir_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[ADDR_W-1 -: 2] == 2'b10) |-> !xl_req);

    // R11: response valid one cycle after request valid.
    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3: error-level low-window access gives identity and match.
    p_erl_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_vaddr[ADDR_W-1] && err_level) |=>
        (rsp_paddr == $past(req_vaddr) && rsp_writable && rsp_code == 2'b00));

    // R8: a refused access returns bad-address with zero address.
    p_refuse_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !allowed) |=>
        (rsp_code == 2'b01 && rsp_paddr == '0 && !rsp_writable));

    // R2: a raised request forwards the translation result.
    p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> (rsp_code == $past(xl_code) && rsp_paddr == $past(xl_paddr)));
endmodule

// File: tb/seg_addr_decoder_bench.sv
module seg_addr_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_mode = '0;
    logic        err_level = 1'b0;
    logic        xl_req;
    logic [1:0]  xl_code = '0;
    logic [31:0] xl_paddr = '0;
    logic        xl_writable = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_writable;
    logic [1:0]  rsp_code;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [1:0] K = 2'b00, S = 2'b01, U = 2'b10, X = 2'b11;
    localparam logic [1:0] C_MATCH = 2'b00, C_BAD = 2'b01, C_NOM = 2'b10, C_INV = 2'b11;

    always #10 clk = ~clk;

    seg_addr_decoder u_seg_addr_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_mode(req_mode), .err_level(err_level), .xl_req(xl_req),
        .xl_code(xl_code), .xl_paddr(xl_paddr), .xl_writable(xl_writable),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_writable(rsp_writable), .rsp_code(rsp_code)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic stub(input logic [1:0] c, input logic [31:0] pa, input logic w);
        xl_code = c; xl_paddr = pa; xl_writable = w;
    endtask

    // One access: drive at negedge, check request, check registered response.
    task automatic access(input string tag, input logic [31:0] va, input logic [1:0] md,
                          input logic erl, input logic exp_req, input logic [1:0] exp_code,
                          input logic [31:0] exp_pa, input logic exp_w);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_mode = md; err_level = erl;
        #1 chk(tag, "xl_req", 32'(xl_req), 32'(exp_req));
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(tag, "rsp_code", 32'(rsp_code), 32'(exp_code));
        chk(tag, "rsp_paddr", rsp_paddr, exp_pa);
        chk(tag, "rsp_writable", 32'(rsp_writable), 32'(exp_w));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "rsp_paddr", rsp_paddr, 0);
        chk("R1", "rsp_code", 32'(rsp_code), 0);
        chk("R1", "rsp_writable", 32'(rsp_writable), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after release", 32'(rsp_valid), 0);
    endtask

    task automatic t_low_mapped;
        stub(C_MATCH, 32'h1234_5000, 1'b1);
        access("R2", 32'h0000_1000, K, 1'b0, 1'b1, C_MATCH, 32'h1234_5000, 1'b1);
        stub(C_NOM, 32'hDEAD_0000, 1'b0);
        access("R2", 32'h7FFF_FFFF, U, 1'b0, 1'b1, C_NOM, 32'hDEAD_0000, 1'b0);
        stub(C_INV, 32'h0F0F_0000, 1'b1);
        access("R2", 32'h0000_0100, X, 1'b0, 1'b1, C_INV, 32'h0F0F_0000, 1'b1);
    endtask

    task automatic t_err_level;
        stub(C_NOM, 32'hAAAA_AAAA, 1'b0);
        access("R3", 32'h7FFF_FFFF, U, 1'b1, 1'b0, C_MATCH, 32'h7FFF_FFFF, 1'b1);
        access("R3", 32'h0000_0040, S, 1'b1, 1'b0, C_MATCH, 32'h0000_0040, 1'b1);
        access("R3", 32'h1357_9BDF, K, 1'b1, 1'b0, C_MATCH, 32'h1357_9BDF, 1'b1);
    endtask

    task automatic t_direct;
        stub(C_NOM, 32'h5555_5555, 1'b0);
        access("R4", 32'h8000_0000, K, 1'b0, 1'b0, C_MATCH, 32'h0000_0000, 1'b1);
        access("R4", 32'h9FFF_FFFF, K, 1'b0, 1'b0, C_MATCH, 32'h1FFF_FFFF, 1'b1);
        access("R5", 32'hA000_0000, K, 1'b0, 1'b0, C_MATCH, 32'h0000_0000, 1'b1);
        access("R5", 32'hBFFF_FFFC, K, 1'b0, 1'b0, C_MATCH, 32'h1FFF_FFFC, 1'b1);
    endtask

    task automatic t_upper_mapped;
        stub(C_INV, 32'h0ABC_0000, 1'b0);
        access("R6", 32'hC000_0000, S, 1'b0, 1'b1, C_INV, 32'h0ABC_0000, 1'b0);
        stub(C_MATCH, 32'h3000_0FFF, 1'b1);
        access("R6", 32'hDFFF_FFFF, K, 1'b0, 1'b1, C_MATCH, 32'h3000_0FFF, 1'b1);
        stub(C_MATCH, 32'h0765_4000, 1'b1);
        access("R7", 32'hE000_0000, K, 1'b0, 1'b1, C_MATCH, 32'h0765_4000, 1'b1);
    endtask

    task automatic t_refuse;
        stub(C_MATCH, 32'h7777_7777, 1'b1);
        access("R8", 32'h8000_1000, S, 1'b0, 1'b0, C_BAD, 32'h0, 1'b0);
        access("R8", 32'hA000_0000, U, 1'b0, 1'b0, C_BAD, 32'h0, 1'b0);
        access("R8", 32'hC000_0000, U, 1'b0, 1'b0, C_BAD, 32'h0, 1'b0);
        access("R7", 32'hFFFF_FFFF, S, 1'b0, 1'b0, C_BAD, 32'h0, 1'b0);
        access("R8", 32'hE000_0000, U, 1'b0, 1'b0, C_BAD, 32'h0, 1'b0);
        access("R9", 32'h8000_0000, X, 1'b0, 1'b0, C_BAD, 32'h0, 1'b0);
        access("R9", 32'hC000_0000, X, 1'b0, 1'b0, C_BAD, 32'h0, 1'b0);
        access("R10", 32'h8000_0000, U, 1'b0, 1'b0, C_BAD, 32'h0, 1'b0);
    endtask

    task automatic t_erl_high;
        stub(C_MATCH, 32'h0246_8000, 1'b1);
        access("R12", 32'hE000_0010, K, 1'b1, 1'b1, C_MATCH, 32'h0246_8000, 1'b1);
        access("R12", 32'hA000_0000, U, 1'b1, 1'b0, C_BAD, 32'h0, 1'b0);
        access("R12", 32'h8000_0020, K, 1'b1, 1'b0, C_MATCH, 32'h0000_0020, 1'b1);
    endtask

    task automatic t_idle;
        stub(C_MATCH, 32'h1111_0000, 1'b1);
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = 32'hC000_0000; req_mode = K; err_level = 1'b0;
        #1 chk("R11", "xl_req idle", 32'(xl_req), 0);
        @(negedge clk);
        chk("R11", "rsp_valid idle", 32'(rsp_valid), 0);
    endtask

    initial begin
        t_reset();
        t_low_mapped();
        t_err_level();
        t_direct();
        t_upper_mapped();
        t_refuse();
        t_erl_high();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule